// File: doc/BRIEF.md
# Power source status register block

This block is a small memory-mapped peripheral that tells software about the machine's power sources. It holds an AC-present flag and four battery values: a status code, a health code, a presence flag and a charge capacity. Hardware writes these values through a property-update port. Each update is tagged either as mains (AC) or as battery. The block stores the codes as given and does not interpret them.

Every accepted update latches a change bit. An AC update sets bit 0 and a battery update sets bit 1. A two-bit enable mask gates the latched bits onto a level interrupt line. Software reads the interrupt-status offset to learn which enabled changes occurred, and that read also acknowledges them. A build parameter declares that no battery is fitted. In that build, every property update is discarded.

Top module: `pwr_status_regs`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: An update with `upd_is_ac`=1 and field code 0 stores `upd_value[0]` as the AC flag, read at offset 2. An AC update with any other field code stores nothing. Any accepted AC update sets change bit 0, and it leaves the four battery values untouched.
- R3: An update with `upd_is_ac`=0 stores the low bits of `upd_value` by field code: 0 is status (offset 3), 1 is health (offset 4), 2 is presence (offset 5, one bit) and 3 is capacity (offset 6, CAP_W bits). Any accepted battery update sets change bit 1.
- R4: A bus write to offset 1 loads the enable mask from `bus_wdata[1:0]`. Reading offset 1 returns the mask, with all higher bits zero.
- R5: One cycle after an update or an enable write, `irq` equals (pending AND enable) being nonzero.
- R6: A read of offset 0 returns pending AND enable in bits [1:0].
  - When that value is nonzero, all pending bits clear and `irq` is low on the next cycle.
  - When it is zero, the pending bits are kept.
- R7: When an update and an acknowledging status read fall in the same cycle, the read returns the old bits, and the change bit of the new update remains pending afterwards.
- R8: When the block is built with HAS_BATTERY=0, updates have no effect. The stored values stay zero, no change bit is set, and `irq` stays low.
- R9: Offsets 7 and above read zero. Bus writes to any offset other than 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Property update strobe |
| upd_is_ac | input | 1 | 1 = AC update, 0 = battery update |
| upd_field | input | 2 | Property code (see R2, R3) |
| upd_value | input | DATA_W | Property value |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of `bus_rd` |
| irq | output | 1 | Level interrupt |

## Verification
A property update and an acknowledging read of the status offset can land on the same clock edge. One then clears the pending set while the other adds to it.

The bench raises one change bit and waits for the interrupt. It then drives a battery update and a status read in a single cycle. The scoreboard expects the read to return only the old AC bit. A second status read must then return the battery bit alone, after which the interrupt must be low.

// File: rtl/pwr_status_pkg.sv
package pwr_status_pkg;
   // register offsets (word addressed)
   localparam int OFS_CHG_STAT = 0;
   localparam int OFS_CHG_EN   = 1;
   localparam int OFS_MAINS    = 2;
   localparam int OFS_BSTAT    = 3;
   localparam int OFS_BHEALTH  = 4;
   localparam int OFS_BPRES    = 5;
   localparam int OFS_BCAP     = 6;
   localparam int OFS_LAST     = OFS_BCAP;

   // change bits
   localparam int CHG_W    = 2;
   localparam int CHG_MAIN = 0;
   localparam int CHG_BATT = 1;

   // property codes
   typedef enum logic [1:0] {
      PF_STAT   = 2'd0,
      PF_HEALTH = 2'd1,
      PF_PRES   = 2'd2,
      PF_CAP    = 2'd3
   } prop_code_e;
   localparam logic [1:0] PF_MAINS_ON = 2'd0;

   function automatic logic [CHG_W-1:0] chg_mask(input logic take, input logic is_ac);
      logic [CHG_W-1:0] m;
      m = '0;
      if (take) m[is_ac ? CHG_MAIN : CHG_BATT] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/pwr_upd_gate.sv
module pwr_upd_gate #(
   parameter bit HAS_BATTERY = 1'b1
) (
   input  logic upd_valid_i,
   output logic take_o
);
   generate
      if (HAS_BATTERY) begin : g_fitted
         assign take_o = upd_valid_i;
      end else begin : g_absent
         logic unused_valid;
         assign unused_valid = upd_valid_i;
         assign take_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pwr_prop_store.sv
module pwr_prop_store
   import pwr_status_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int STATUS_W = 8,
   parameter int HEALTH_W = 8,
   parameter int CAP_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take_i,
   input  logic                is_ac_i,
   input  logic [1:0]          field_i,
   input  logic [DATA_W-1:0]   value_i,
   output logic                mains_o,
   output logic [STATUS_W-1:0] bstat_o,
   output logic [HEALTH_W-1:0] bhealth_o,
   output logic                bpres_o,
   output logic [CAP_W-1:0]    bcap_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mains_o   <= 1'b0;
         bstat_o   <= '0;
         bhealth_o <= '0;
         bpres_o   <= 1'b0;
         bcap_o    <= '0;
      end else if (take_i) begin
         if (is_ac_i) begin
            if (field_i == PF_MAINS_ON) mains_o <= value_i[0];
         end else begin
            case (prop_code_e'(field_i))
               PF_STAT:   bstat_o   <= value_i[STATUS_W-1:0];
               PF_HEALTH: bhealth_o <= value_i[HEALTH_W-1:0];
               PF_PRES:   bpres_o   <= value_i[0];
               PF_CAP:    bcap_o    <= value_i[CAP_W-1:0];
               default:   ;
            endcase
         end
      end
   end

   // R2: a mains update never disturbs battery values
   p_mains_keeps_batt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && is_ac_i) |=> ($stable(bstat_o) && $stable(bhealth_o) && $stable(bpres_o) && $stable(bcap_o)));
   // R8: without an accepted update nothing stored moves
   p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!take_i && !$fell(rst_n)) |=> ($stable(mains_o) && $stable(bstat_o) && $stable(bcap_o)));
endmodule

// File: rtl/pwr_irq_ctrl.sv
module pwr_irq_ctrl
   import pwr_status_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CHG_W-1:0] set_i,
   input  logic             stat_rd_i,
   input  logic             en_we_i,
   input  logic [CHG_W-1:0] en_wdata_i,
   output logic [CHG_W-1:0] en_o,
   output logic [CHG_W-1:0] pend_o,
   output logic             irq_o
);
   logic [CHG_W-1:0] seen;
   logic             ack;
   logic [CHG_W-1:0] pend_d, en_d;

   assign seen   = pend_o & en_o;
   assign ack    = stat_rd_i && (|seen);
   assign pend_d = (ack ? '0 : pend_o) | set_i;
   assign en_d   = en_we_i ? en_wdata_i : en_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_o <= '0;
         en_o   <= '0;
         irq_o  <= 1'b0;
      end else begin
         pend_o <= pend_d;
         en_o   <= en_d;
         irq_o  <= |(pend_d & en_d);
      end
   end

   p_ack_lowers_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && set_i == '0 && !en_we_i) |=> (!irq_o && pend_o == '0));
   p_noack_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd_i && !ack && set_i == '0) |=> $stable(pend_o));
   p_new_bit_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && set_i[CHG_BATT]) |=> pend_o[CHG_BATT]);
   p_enabled_set_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(set_i & en_o)) && !en_we_i) |=> irq_o);
endmodule

// File: rtl/pwr_status_regs.sv
module pwr_status_regs
   import pwr_status_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int STATUS_W    = 8,
   parameter int HEALTH_W    = 8,
   parameter int CAP_W       = 8,
   parameter bit HAS_BATTERY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_valid,
   input  logic              upd_is_ac,
   input  logic [1:0]        upd_field,
   input  logic [DATA_W-1:0] upd_value,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int MAX_OFS = (1 << ADDR_W) - 1;

   generate
      if (ADDR_W < 3 || MAX_OFS < OFS_LAST) begin : g_bad_addr
         $error("ADDR_W too small for register map");
      end
      if (STATUS_W > DATA_W || HEALTH_W > DATA_W || CAP_W > DATA_W || DATA_W < CHG_W) begin : g_bad_width
         $error("field width exceeds DATA_W");
      end
   endgenerate

   logic                take;
   logic [CHG_W-1:0]    set_bits, en_q, pend_q;
   logic                mains_q, bpres_q;
   logic [STATUS_W-1:0] bstat_q;
   logic [HEALTH_W-1:0] bhealth_q;
   logic [CAP_W-1:0]    bcap_q;
   logic                stat_rd, en_we;

   pwr_upd_gate #(.HAS_BATTERY(HAS_BATTERY)) u_gate (
      .upd_valid_i(upd_valid), .take_o(take));

   assign set_bits = chg_mask(take, upd_is_ac);
   assign stat_rd  = bus_rd && (bus_addr == ADDR_W'(OFS_CHG_STAT));
   assign en_we    = bus_wr && (bus_addr == ADDR_W'(OFS_CHG_EN));

   pwr_prop_store #(.DATA_W(DATA_W), .STATUS_W(STATUS_W), .HEALTH_W(HEALTH_W), .CAP_W(CAP_W)) u_store (
      .clk(clk), .rst_n(rst_n), .take_i(take), .is_ac_i(upd_is_ac),
      .field_i(upd_field), .value_i(upd_value),
      .mains_o(mains_q), .bstat_o(bstat_q), .bhealth_o(bhealth_q),
      .bpres_o(bpres_q), .bcap_o(bcap_q));

   pwr_irq_ctrl u_irq (
      .clk(clk), .rst_n(rst_n), .set_i(set_bits), .stat_rd_i(stat_rd),
      .en_we_i(en_we), .en_wdata_i(bus_wdata[CHG_W-1:0]),
      .en_o(en_q), .pend_o(pend_q), .irq_o(irq));

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (int'(bus_addr))
            OFS_CHG_STAT: bus_rdata[CHG_W-1:0]    = pend_q & en_q;
            OFS_CHG_EN:   bus_rdata[CHG_W-1:0]    = en_q;
            OFS_MAINS:    bus_rdata[0]            = mains_q;
            OFS_BSTAT:    bus_rdata[STATUS_W-1:0] = bstat_q;
            OFS_BHEALTH:  bus_rdata[HEALTH_W-1:0] = bhealth_q;
            OFS_BPRES:    bus_rdata[0]            = bpres_q;
            OFS_BCAP:     bus_rdata[CAP_W-1:0]    = bcap_q;
            default:      bus_rdata = '0;
         endcase
      end
   end

   // R8: a build without battery never raises the line
   p_nobatt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!HAS_BATTERY) |-> (!irq && pend_q == '0));
   // R1: first cycle out of reset has the line low
   p_reset_low_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> !irq);
endmodule

// File: tb/tb_pwr_status_regs.sv
`timescale 1ns/1ps
module tb_pwr_status_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_valid = 1'b0, upd_is_ac = 1'b0;
   logic [1:0]  upd_field = '0;
   logic [31:0] upd_value = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata, nb_rdata;
   logic        irq, nb_irq;

   int checks = 0, errors = 0;
   bit mon_en = 1'b1;
   bit done = 1'b0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   pwr_status_regs dut (
      .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_is_ac(upd_is_ac),
      .upd_field(upd_field), .upd_value(upd_value), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   pwr_status_regs #(.HAS_BATTERY(1'b0)) dut_nb (
      .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_is_ac(upd_is_ac),
      .upd_field(upd_field), .upd_value(upd_value), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(nb_rdata), .irq(nb_irq));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (mon_en && bus_rd) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL scoreboard actual %h expected <none>", bus_rdata);
         end else begin
            chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
         end
      end
   end

   task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
      @(posedge clk); #1;
      bus_rd = 1'b1; bus_addr = a;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic upd(input logic ac, input logic [1:0] f, input logic [31:0] v);
      @(posedge clk); #1;
      upd_valid = 1'b1; upd_is_ac = ac; upd_field = f; upd_value = v;
      @(posedge clk); #1;
      upd_valid = 1'b0;
   endtask

   task automatic rd_upd(input logic [31:0] exp, input string tag,
                         input logic ac, input logic [1:0] f, input logic [31:0] v);
      @(posedge clk); #1;
      bus_rd = 1'b1; bus_addr = 4'd0;
      exp_q.push_back(exp); tag_q.push_back(tag);
      upd_valid = 1'b1; upd_is_ac = ac; upd_field = f; upd_value = v;
      @(posedge clk); #1;
      bus_rd = 1'b0; upd_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      chk("R1 irq after reset", {31'b0, irq}, 32'd0);
      for (int i = 0; i <= 6; i++) rd(4'(i), 32'd0, "R1 reset value");
      rd(4'd9, 32'd0, "R9 undefined offset");

      wr(4'd1, 32'hFFFF_FFFF);
      rd(4'd1, 32'd3, "R4 enable readback");
      chk("R5 no pending no irq", {31'b0, irq}, 32'd0);
      wr(4'd1, 32'd0);

      upd(1'b1, 2'd0, 32'd1);
      rd(4'd2, 32'd1, "R2 mains flag");
      chk("R5 masked change", {31'b0, irq}, 32'd0);
      rd(4'd0, 32'd0, "R6 masked status read");
      wr(4'd1, 32'd1);
      chk("R5 enable write raises", {31'b0, irq}, 32'd1);
      rd(4'd0, 32'd1, "R6 status mains bit");
      chk("R6 ack lowers irq", {31'b0, irq}, 32'd0);
      rd(4'd0, 32'd0, "R6 cleared");

      upd(1'b0, 2'd0, 32'd5);
      upd(1'b0, 2'd1, 32'd2);
      upd(1'b0, 2'd2, 32'd1);
      upd(1'b0, 2'd3, 32'h1FF);
      rd(4'd3, 32'd5, "R3 status");
      rd(4'd4, 32'd2, "R3 health");
      rd(4'd5, 32'd1, "R3 presence");
      rd(4'd6, 32'hFF, "R3 capacity truncated");
      chk("R5 battery bit masked", {31'b0, irq}, 32'd0);
      wr(4'd1, 32'd3);
      chk("R5 enable battery raises", {31'b0, irq}, 32'd1);
      rd(4'd0, 32'd2, "R6 status battery bit");
      chk("R6 ack lowers irq battery", {31'b0, irq}, 32'd0);

      upd(1'b1, 2'd2, 32'hAB);
      chk("R2 mains update raises", {31'b0, irq}, 32'd1);
      rd(4'd2, 32'd1, "R2 non-flag code ignored");
      rd(4'd3, 32'd5, "R2 battery untouched");
      rd(4'd0, 32'd1, "R2 mains change bit");

      upd(1'b1, 2'd0, 32'd0);
      rd_upd(32'd1, "R7 read returns old bits", 1'b0, 2'd3, 32'h11);
      chk("R7 irq stays for new bit", {31'b0, irq}, 32'd1);
      rd(4'd0, 32'd2, "R7 battery bit kept");
      chk("R7 irq low after ack", {31'b0, irq}, 32'd0);
      rd(4'd2, 32'd0, "R2 mains flag cleared");

      wr(4'd6, 32'd0);
      wr(4'd0, 32'd3);
      rd(4'd6, 32'h11, "R9 write to read-only");
      rd(4'd0, 32'd0, "R9 status write ignored");

      // no-battery build, observed through its own outputs
      chk("R8 irq stays low", {31'b0, nb_irq}, 32'd0);
      mon_en = 1'b0;
      for (int i = 0; i <= 6; i++) begin
         @(posedge clk); #1;
         bus_rd = 1'b1; bus_addr = 4'(i);
         #1;
         chk("R8 value unchanged", nb_rdata, (i == 1) ? 32'd3 : 32'd0);
         @(posedge clk); #1;
         bus_rd = 1'b0;
      end
      mon_en = 1'b1;
      repeat (2) @(posedge clk);
      if (exp_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard actual %0d left expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule